// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Sequencer

This block sits on the CPU side of an 8-bit processor bus. It takes a maskable interrupt request and turns it into the 16-bit address of the handler. When a request is accepted, it runs an acknowledge cycle. During that cycle the machine-cycle strobe and the I/O strobe are both driven low together, and the interrupting device's 8-bit vector is taken from the data bus.

In vectored mode, the vector becomes the low byte of a table pointer, and an internal page register supplies the high byte. The sequencer then makes two byte reads over a request/ready memory port. The low byte of the handler comes from the pointer and the high byte from the pointer plus one. The vector's low bit is never cleared, and the increment carries across all 16 bits. An odd vector therefore reads an odd table entry, and a vector of 0xFF takes its high byte from the start of the next page.

In fixed restart mode, no table is read and the handler is always 0x0038. In both modes the result is presented for one cycle with a done pulse, and the sequencer then returns to idle.

Top module: `vec_irq_seq`

## Requirements
- R1: After reset, `intEnabled` is 0, `m1N` and `iorqN` are 1, and `memReq` and `doneValid` are 0.
- R2: While `intEnabled` is 0, a low `irqReqN` starts no acknowledge cycle, no memory read and no done pulse.
- R3: Accepting a request clears `intEnabled` in the same edge. A request that stays low afterwards starts no second sequence until `intEnSet` is pulsed again.
- R4: The acknowledge cycle drives `m1N` and `iorqN` low together for exactly ACK_CYCLES clock cycles, never one without the other. No memory request is made during it.
- R5: In vectored mode (`modeVectored`=1), the pointer is {page, vector}, with the vector taken from `dataIn` during acknowledge and bit 0 kept as supplied. The first read goes to the pointer and the second to pointer+1.
- R6: The +1 carries into the upper byte. Vector 0xFF with page P reads {P,0xFF} and then {P+1,0x00}, and page 0xFF wraps to 0x0000. An undriven bus, which reads as 0xFF through the pull-ups, behaves the same way.
- R7: `memReq` stays high with a stable `memAddr` until `memReady` is seen high, and exactly one byte is taken for each handshake, for any number of wait cycles.
- R8: `doneValid` is high for exactly one cycle, with `handlerAddr` = {second byte, first byte}. The sequencer then returns to idle.
- R9: In fixed mode (`modeVectored`=0), the acknowledge cycle still runs, no memory reads occur, and `handlerAddr` is 0x0038.
- R10: `modeVectored` is sampled at acceptance. Changing it during the sequence has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqReqN | input | 1 | Maskable interrupt request, active low |
| intEnSet | input | 1 | Sets the interrupt enable flag |
| intEnabled | output | 1 | Current state of the interrupt enable flag |
| modeVectored | input | 1 | 1 = table-vectored mode, 0 = fixed restart mode |
| pageWe | input | 1 | Write strobe for the page register |
| pageDin | input | 8 | New page register value |
| m1N | output | 1 | Machine-cycle strobe, low during acknowledge |
| iorqN | output | 1 | I/O strobe, low during acknowledge |
| dataIn | input | 8 | Data bus input carrying the device vector |
| memReq | output | 1 | Byte read request |
| memAddr | output | 16 | Byte read address |
| memData | input | 8 | Byte read data |
| memReady | input | 1 | Read data valid; completes the handshake |
| doneValid | output | 1 | One-cycle pulse; handler address valid |
| handlerAddr | output | 16 | Assembled handler address |

## Verification
The bound checker watches every cycle for the following properties:
- the acknowledge strobes appear only with the enable flag already cleared and with no memory request alongside them;
- a pending read holds its request and address steady;
- the done pulse never lasts beyond one cycle and never overlaps bus activity.

Some behaviours can only be shown by the directed scenarios:
- the two read addresses produced for even, odd and page-wrapping vectors;
- the assembled handler value;
- the fixed 0x0038 result;
- masking, and the refusal to re-enter;
- insensitivity to a mode change made mid-sequence.

// File: rtl/vis_pkg.sv
package vis_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK,
    ST_RDLO,
    ST_RDHI,
    ST_DONE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearEn;     // acceptance: drop the enable flag
    logic captureVec;  // last acknowledge cycle: latch pointer
    logic captureLo;   // first read completes
    logic captureHi;   // second read completes
    logic addrHi;      // present pointer+1 instead of pointer
    logic useFixed;    // report the restart address
  } ctlStrb_t;

endpackage

// File: rtl/vis_ctrl.sv
module vis_ctrl
  import vis_pkg::*;
#(
  parameter int ACK_CYCLES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     irqReqN,
  input  logic     intEnabled,
  input  logic     modeVectored,
  input  logic     memReady,
  output ctlStrb_t strb,
  output logic     m1N,
  output logic     iorqN,
  output logic     memReq,
  output logic     doneValid
);

  localparam int CNT_W = (ACK_CYCLES < 2) ? 1 : $clog2(ACK_CYCLES);
  localparam logic [CNT_W-1:0] ACK_LAST = CNT_W'(ACK_CYCLES - 1);

  seqState_t state, nextState;
  logic [CNT_W-1:0] ackCnt;
  logic modeLatched;
  logic accept;

  assign accept = (state == ST_IDLE) && intEnabled && !irqReqN;

  always_comb begin
    nextState = state;
    strb      = '0;
    m1N       = 1'b1;
    iorqN     = 1'b1;
    memReq    = 1'b0;
    doneValid = 1'b0;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          strb.clearEn = 1'b1;
          nextState    = ST_ACK;
        end
      end
      ST_ACK: begin
        m1N   = 1'b0;
        iorqN = 1'b0;
        if (ackCnt == ACK_LAST) begin
          strb.captureVec = 1'b1;
          nextState       = modeLatched ? ST_RDLO : ST_DONE;
        end
      end
      ST_RDLO: begin
        memReq = 1'b1;
        if (memReady) begin
          strb.captureLo = 1'b1;
          nextState      = ST_RDHI;
        end
      end
      ST_RDHI: begin
        memReq      = 1'b1;
        strb.addrHi = 1'b1;
        if (memReady) begin
          strb.captureHi = 1'b1;
          nextState      = ST_DONE;
        end
      end
      ST_DONE: begin
        doneValid     = 1'b1;
        strb.useFixed = !modeLatched;
        nextState     = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      ackCnt      <= '0;
      modeLatched <= 1'b0;
    end else begin
      state <= nextState;
      if (accept) begin
        modeLatched <= modeVectored;
        ackCnt      <= '0;
      end else if (state == ST_ACK) begin
        ackCnt <= ackCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/vis_dpath.sv
module vis_dpath
  import vis_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter logic [15:0] FIXED_ADDR = 16'h0038
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrb_t            strb,
  input  logic                intEnSet,
  input  logic                pageWe,
  input  logic [DATA_W-1:0]   pageDin,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic [DATA_W-1:0]   memData,
  output logic [2*DATA_W-1:0] memAddr,
  output logic [2*DATA_W-1:0] handlerAddr,
  output logic                intEnabled
);

  localparam int ADDR_W = 2 * DATA_W;

  logic [DATA_W-1:0] pageReg;
  logic [ADDR_W-1:0] ptrReg;
  logic [DATA_W-1:0] loByte, hiByte;
  logic              intEnReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg  <= '0;
      ptrReg   <= '0;
      loByte   <= '0;
      hiByte   <= '0;
      intEnReg <= 1'b0;
    end else begin
      if (pageWe)          pageReg  <= pageDin;
      if (strb.clearEn)    intEnReg <= 1'b0;
      else if (intEnSet)   intEnReg <= 1'b1;
      // vector low bit kept exactly as the device supplied it
      if (strb.captureVec) ptrReg   <= {pageReg, dataIn};
      if (strb.captureLo)  loByte   <= memData;
      if (strb.captureHi)  hiByte   <= memData;
    end
  end

  // full-width increment: carry propagates into the page byte
  assign memAddr     = strb.addrHi ? ptrReg + ADDR_W'(1) : ptrReg;
  assign handlerAddr = strb.useFixed ? ADDR_W'(FIXED_ADDR) : {hiByte, loByte};
  assign intEnabled  = intEnReg;

endmodule

// File: rtl/vec_irq_seq.sv
module vec_irq_seq
  import vis_pkg::*;
#(
  parameter int          ACK_CYCLES = 2,
  parameter logic [15:0] FIXED_ADDR = 16'h0038
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        irqReqN,
  input  logic        intEnSet,
  output logic        intEnabled,
  input  logic        modeVectored,
  input  logic        pageWe,
  input  logic [7:0]  pageDin,
  output logic        m1N,
  output logic        iorqN,
  input  logic [7:0]  dataIn,
  output logic        memReq,
  output logic [15:0] memAddr,
  input  logic [7:0]  memData,
  input  logic        memReady,
  output logic        doneValid,
  output logic [15:0] handlerAddr
);

  ctlStrb_t strb;

  vis_ctrl #(.ACK_CYCLES(ACK_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .irqReqN(irqReqN), .intEnabled(intEnabled),
    .modeVectored(modeVectored), .memReady(memReady), .strb(strb),
    .m1N(m1N), .iorqN(iorqN), .memReq(memReq), .doneValid(doneValid)
  );

  vis_dpath #(.DATA_W(8), .FIXED_ADDR(FIXED_ADDR)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .intEnSet(intEnSet),
    .pageWe(pageWe), .pageDin(pageDin), .dataIn(dataIn), .memData(memData),
    .memAddr(memAddr), .handlerAddr(handlerAddr), .intEnabled(intEnabled)
  );

endmodule

// File: rtl/vec_irq_seq_chk.sv
module vec_irq_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        intEnabled,
  input logic        m1N,
  input logic        iorqN,
  input logic        memReq,
  input logic [15:0] memAddr,
  input logic        memReady,
  input logic        doneValid
);

  assert_ack_clears_en_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(iorqN) |-> !intEnabled);

  assert_ack_no_mem_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!iorqN || !m1N) |-> !memReq);

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (iorqN && m1N && !memReq));

endmodule

bind vec_irq_seq vec_irq_seq_chk uChk (
  .clk(clk), .rstN(rstN), .intEnabled(intEnabled), .m1N(m1N), .iorqN(iorqN),
  .memReq(memReq), .memAddr(memAddr), .memReady(memReady), .doneValid(doneValid)
);

// File: tb/vec_irq_seq_test.sv
module vec_irq_seq_test;

  localparam int ACK_CYCLES = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irqReqN = 1'b1, intEnSet = 1'b0, modeVectored = 1'b1, pageWe = 1'b0;
  logic [7:0] pageDin = 8'h00, dataIn = 8'h00, memData = 8'h00;
  logic memReady = 1'b0;
  logic intEnabled, m1N, iorqN, memReq, doneValid;
  logic [15:0] memAddr, handlerAddr;

  int errors = 0, checks = 0;
  int memWait = 0, waitCnt = 0;
  int ackLow = 0, pairBad = 0, nReads = 0, doneSeen = 0;
  logic [15:0] prevAddr = '0, lastAddr = '0;

  always #10 clk = ~clk;

  vec_irq_seq #(.ACK_CYCLES(ACK_CYCLES)) uut (
    .clk(clk), .rstN(rstN), .irqReqN(irqReqN), .intEnSet(intEnSet),
    .intEnabled(intEnabled), .modeVectored(modeVectored), .pageWe(pageWe),
    .pageDin(pageDin), .m1N(m1N), .iorqN(iorqN), .dataIn(dataIn),
    .memReq(memReq), .memAddr(memAddr), .memData(memData),
    .memReady(memReady), .doneValid(doneValid), .handlerAddr(handlerAddr)
  );

  function automatic logic [7:0] memByte(input logic [15:0] a);
    logic [7:0] v;
    v = (a[7:0] * 8'd3) + a[15:8];
    return v ^ 8'hA5;
  endfunction

  // memory model: answers after memWait idle cycles
  always @(negedge clk) begin
    if (memReq && !memReady) begin
      if (waitCnt >= memWait) begin
        memReady <= 1'b1;
        memData  <= memByte(memAddr);
        prevAddr <= lastAddr;
        lastAddr <= memAddr;
        nReads   <= nReads + 1;
        waitCnt  <= 0;
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end else begin
      memReady <= 1'b0;
    end
  end

  // bus monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (!iorqN) ackLow <= ackLow + 1;
      if (m1N != iorqN) pairBad <= pairBad + 1;
      if (doneValid) doneSeen <= doneSeen + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic setPage(input logic [7:0] p);
    @(negedge clk); pageWe = 1'b1; pageDin = p;
    @(negedge clk); pageWe = 1'b0;
  endtask

  // enable, then raise the request; returns counter snapshots
  task automatic startSeq(output int ackB, output int rdB, output int dnB);
    @(negedge clk); intEnSet = 1'b1;
    @(negedge clk); intEnSet = 1'b0;
    ackB = ackLow; rdB = nReads; dnB = doneSeen;
    irqReqN = 1'b0;
  endtask

  task automatic waitDone(output bit seen, output logic [15:0] h, input bit flipMode);
    seen = 1'b0; h = '0;
    for (int t = 0; t < 300; t++) begin
      @(negedge clk);
      if (flipMode && t == 0) modeVectored = ~modeVectored;
      if (doneValid) begin seen = 1'b1; h = handlerAddr; break; end
    end
    irqReqN = 1'b1;
    @(negedge clk);
    check(!doneValid, "R8", "done pulse one cycle", {31'd0, doneValid}, 32'd0);
    check(iorqN && !memReq, "R8", "idle after done", {30'd0, iorqN, memReq}, 32'd2);
  endtask

  task automatic vecCase(input string req, input logic [7:0] page,
                         input logic [7:0] vec, input int wt);
    int ackB, rdB, dnB; bit seen; logic [15:0] h, p0, p1;
    setPage(page); dataIn = vec; modeVectored = 1'b1; memWait = wt;
    p0 = {page, vec}; p1 = p0 + 16'd1;
    startSeq(ackB, rdB, dnB);
    waitDone(seen, h, 1'b0);
    check(seen, req, "done seen", {31'd0, seen}, 32'd1);
    check(ackLow - ackB == ACK_CYCLES, "R4", "ack length", ackLow - ackB, ACK_CYCLES);
    check(nReads - rdB == 2, "R7", "read count", nReads - rdB, 2);
    check(prevAddr == p0, req, "first read addr", {16'd0, prevAddr}, {16'd0, p0});
    check(lastAddr == p1, req, "second read addr", {16'd0, lastAddr}, {16'd0, p1});
    check(h == {memByte(p1), memByte(p0)}, "R8", "handler value",
          {16'd0, h}, {16'd0, memByte(p1), memByte(p0)});
    check(!intEnabled, "R3", "enable cleared", {31'd0, intEnabled}, 32'd0);
  endtask

  task automatic testReset();
    check(!intEnabled && m1N && iorqN && !memReq && !doneValid, "R1", "reset outputs",
          {27'd0, intEnabled, m1N, iorqN, memReq, doneValid}, 32'b01100);
  endtask

  task automatic testMasked();
    int a, r, d;
    a = ackLow; r = nReads; d = doneSeen;
    irqReqN = 1'b0;
    repeat (12) @(negedge clk);
    irqReqN = 1'b1;
    check(ackLow == a && nReads == r && doneSeen == d, "R2", "masked request ignored",
          ackLow - a + nReads - r + doneSeen - d, 0);
  endtask

  task automatic testNoReenable();
    int a, r, d; bit seen; logic [15:0] h;
    vecCase("R5", 8'h12, 8'h40, 0);
    a = ackLow; d = doneSeen;
    irqReqN = 1'b0;
    repeat (15) @(negedge clk);
    check(ackLow == a && doneSeen == d, "R3", "held request no re-entry",
          ackLow - a + doneSeen - d, 0);
    startSeq(a, r, d);
    waitDone(seen, h, 1'b0);
    check(seen, "R3", "re-enable allows new sequence", {31'd0, seen}, 32'd1);
  endtask

  task automatic testFixed(input bit flip);
    int a, r, d; bit seen; logic [15:0] h;
    dataIn = 8'h5C; modeVectored = 1'b0;
    startSeq(a, r, d);
    waitDone(seen, h, flip);
    check(seen && h == 16'h0038, flip ? "R10" : "R9", "fixed handler",
          {16'd0, h}, 32'h0038);
    check(nReads == r, flip ? "R10" : "R9", "no table reads", nReads - r, 0);
    check(ackLow - a == ACK_CYCLES, "R9", "ack in fixed mode", ackLow - a, ACK_CYCLES);
    modeVectored = 1'b1;
  endtask

  task automatic testModeHoldVectored();
    int a, r, d; bit seen; logic [15:0] h;
    setPage(8'h20); dataIn = 8'h10; modeVectored = 1'b1; memWait = 1;
    startSeq(a, r, d);
    waitDone(seen, h, 1'b1);
    check(nReads - r == 2, "R10", "vectored kept after flip", nReads - r, 2);
    check(h == {memByte(16'h2011), memByte(16'h2010)}, "R10", "handler after flip",
          {16'd0, h}, {16'd0, memByte(16'h2011), memByte(16'h2010)});
    modeVectored = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMasked();
    vecCase("R5", 8'h34, 8'h82, 0);   // even vector
    vecCase("R5", 8'h34, 8'h83, 2);   // odd vector, bit 0 kept
    vecCase("R6", 8'hC1, 8'hFF, 1);   // undriven bus reads 0xFF, carry
    vecCase("R6", 8'hFF, 8'hFF, 0);   // page wrap to 0x0000
    vecCase("R7", 8'h07, 8'h3E, 5);   // long waits
    testNoReenable();
    testFixed(1'b0);
    testFixed(1'b1);
    testModeHoldVectored();
    check(pairBad == 0, "R4", "strobes always paired", pairBad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule